// File: doc/BRIEF.md
# Lockable Configuration Register File

This block is the byte-addressed register map that sits behind a two-wire slave port on an elapsed-time recorder. The protocol engine hands it one accepted byte at a time through a write strobe, address and data. It answers reads combinationally from the address. The map holds the following:

- a configuration byte whose settings drive the alarm logic;
- a 4-byte alarm trip point;
- 10 bytes of general-purpose user storage;
- a read-only window onto the recorder's running time and event counts.

Three high addresses are command locations rather than storage. Writing the reset key asks the recorder to clear its counters. The block only turns that request into a one-cycle pulse when reset is permitted. Permission comes either from an internal enable bit, or from an external enable level when the pin-role bit hands that job to the pin. The other two command locations each arm a permanent lock when they receive their key value on two consecutive accepted writes:

- The write lock freezes the configuration byte and the trip point.
- The memory lock freezes the user bytes.

The two locks are independent of each other. Only a hardware reset releases them. While the protocol engine signals busy, incoming writes are discarded, and a sticky error bit records that this happened.

Top module: `lockcfg_regfile`

## Requirements
- R1: After rst_n, the configuration fields, trip point, user bytes, both locks, the drop error and the reset pulse are all zero.
- R2: Address 00h reads, from bit 7 down: pin role, alarm flag input, write lock, memory lock, output select, reset enable, polarity, rollover input. Only bits 7, 3, 2 and 1 are writable. Writes to bits 6, 5, 4 and 0 have no effect.
- R3: User bytes occupy 01h–0Ah and are read/write. The trip point occupies 0Bh–0Eh, least significant byte at the lowest address, and appears on trip_point. The time value occupies 0Fh–12h and the event value 13h–14h, also least significant byte first. These are read-only, and writes there have no effect.
- R4: An accepted write of 55h to 1Dh drives reset_cmd high for exactly the one cycle after that write. This happens only if the reset enable bit is 1, or if the pin role bit is 1 and ext_rst_en is high. Any other case, or any other data value, gives no pulse.
- R5: Two consecutive accepted writes of AAh to 1Eh set wr_lock, which then stays set until rst_n.
- R6: Two consecutive accepted writes of F0h to 1Fh set mem_lock, which then stays set until rst_n.
- R7: An accepted write to any other address, or with any other value, between the two key writes cancels the first one. A single key write sets no lock.
- R8: With wr_lock set, writes to the configuration byte and the trip point have no effect. User bytes remain writable, and a permitted reset command still pulses.
- R9: With mem_lock set, writes to user bytes have no effect. The configuration byte and the trip point remain writable.
- R10: Addresses 1Dh–1Fh and the unused addresses 15h–1Ch always read 00h.
- R11: A write presented while busy is high changes no state, advances no key sequence and issues no reset pulse. It sets drop_err, which stays set until rst_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| addr | input | ADDR_W | Byte address for writes and reads |
| wdata | input | 8 | Write data |
| busy | input | 1 | High while writes must be discarded |
| rdata | output | 8 | Read data for addr (combinational) |
| ext_rst_en | input | 1 | External reset permission level |
| alarm_flag_in | input | 1 | Alarm state shown in configuration bit 6 |
| rollover_in | input | 1 | Event rollover shown in configuration bit 0 |
| time_in | input | TIME_W | Running total time value |
| events_in | input | EVT_W | Event count value |
| trip_point | output | TRIP_W | Stored alarm trip point |
| pin_role | output | 1 | Configuration bit 7 |
| out_sel | output | 1 | Configuration bit 3 |
| polarity | output | 1 | Configuration bit 1 |
| wr_lock | output | 1 | Configuration and trip point locked |
| mem_lock | output | 1 | User bytes locked |
| reset_cmd | output | 1 | One-cycle counter reset request |
| drop_err | output | 1 | Sticky: a write arrived while busy |

## Verification
The properties assume that the port side presents at most one byte per clock and holds wr_en, addr, wdata and busy steady around the sampling edge. They also assume that busy is a level the engine owns, never a glitch. The bench changes every input only on the falling clock edge. Each write is a single-cycle strobe with wr_en dropped again at the next falling edge. Reads are made with wr_en low, so each key sequence seen by the design is exactly the one the test intends.

// File: rtl/lockcfg_pkg.sv
package lockcfg_pkg;
   localparam int unsigned BYTE_W    = 8;
   // command locations and their key values
   localparam int unsigned A_CFG     = 32'h00;
   localparam int unsigned A_RSTCMD  = 32'h1D;
   localparam int unsigned A_WLKCMD  = 32'h1E;
   localparam int unsigned A_MLKCMD  = 32'h1F;
   localparam logic [7:0]  K_RSTCMD  = 8'h55;
   localparam logic [7:0]  K_WLKCMD  = 8'hAA;
   localparam logic [7:0]  K_MLKCMD  = 8'hF0;

   // writable configuration fields
   typedef struct packed {
      logic pin_role;
      logic out_sel;
      logic rst_en;
      logic polarity;
   } cfg_t;
endpackage

// File: rtl/lockcfg_keyarm.sv
module lockcfg_keyarm #(
   parameter int unsigned REPEAT   = 2,
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned KEY_ADDR = 32'h1E,
   parameter logic [7:0]  KEY_VAL  = 8'hAA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   output logic              locked
);
   localparam int unsigned CNT_W = (REPEAT < 2) ? 1 : $clog2(REPEAT);

   generate
      if (REPEAT < 1) begin : g_bad_repeat
         $error("lockcfg_keyarm: REPEAT must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] seen;
   logic             hit;

   assign hit = (32'(addr) == KEY_ADDR) && (wdata == KEY_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen   <= '0;
         locked <= 1'b0;
      end else if (wr_ok) begin
         if (hit) begin
            if (32'(seen) == REPEAT - 1) begin
               locked <= 1'b1;
               seen   <= '0;
            end else begin
               seen <= seen + 1'b1;
            end
         end else begin
            seen <= '0;
         end
      end
   end
endmodule

// File: rtl/lockcfg_bytebank.sv
module lockcfg_bytebank #(
   parameter int unsigned NBYTES = 10,
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned BASE   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ok,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              protect,
   output logic [NBYTES*8-1:0] bytes_q
);
   generate
      if (NBYTES < 1) begin : g_bad_size
         $error("lockcfg_bytebank: NBYTES must be at least 1");
      end
      for (genvar i = 0; i < NBYTES; i++) begin : g_byte
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_ok && !protect && (32'(addr) == BASE + i))
               q <= wdata;
         end
         assign bytes_q[i*8 +: 8] = q;
      end
   endgenerate
endmodule

// File: rtl/lockcfg_rdmux.sv
module lockcfg_rdmux #(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned USER_BYTES = 10,
   parameter int unsigned TRIP_BYTES = 4,
   parameter int unsigned TIME_BYTES = 4,
   parameter int unsigned EVT_BYTES  = 2,
   parameter int unsigned USER_BASE  = 1,
   parameter int unsigned TRIP_BASE  = 11,
   parameter int unsigned TIME_BASE  = 15,
   parameter int unsigned EVT_BASE   = 19
) (
   input  logic [ADDR_W-1:0]       addr,
   input  logic [7:0]              cfg_byte,
   input  logic [USER_BYTES*8-1:0] user_v,
   input  logic [TRIP_BYTES*8-1:0] trip_v,
   input  logic [TIME_BYTES*8-1:0] time_v,
   input  logic [EVT_BYTES*8-1:0]  evt_v,
   output logic [7:0]              rdata
);
   import lockcfg_pkg::*;

   always_comb begin
      rdata = '0;
      if (32'(addr) == A_CFG) rdata = cfg_byte;
      for (int i = 0; i < USER_BYTES; i++)
         if (32'(addr) == USER_BASE + i) rdata = user_v[i*8 +: 8];
      for (int i = 0; i < TRIP_BYTES; i++)
         if (32'(addr) == TRIP_BASE + i) rdata = trip_v[i*8 +: 8];
      for (int i = 0; i < TIME_BYTES; i++)
         if (32'(addr) == TIME_BASE + i) rdata = time_v[i*8 +: 8];
      for (int i = 0; i < EVT_BYTES; i++)
         if (32'(addr) == EVT_BASE + i) rdata = evt_v[i*8 +: 8];
   end
endmodule

// File: rtl/lockcfg_regfile.sv
module lockcfg_regfile #(
   parameter int unsigned ADDR_W     = 5,
   parameter int unsigned USER_BYTES = 10,
   parameter int unsigned TRIP_W     = 32,
   parameter int unsigned TIME_W     = 32,
   parameter int unsigned EVT_W      = 16,
   parameter int unsigned KEY_REPEAT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wdata,
   input  logic              busy,
   output logic [7:0]        rdata,
   input  logic              ext_rst_en,
   input  logic              alarm_flag_in,
   input  logic              rollover_in,
   input  logic [TIME_W-1:0] time_in,
   input  logic [EVT_W-1:0]  events_in,
   output logic [TRIP_W-1:0] trip_point,
   output logic              pin_role,
   output logic              out_sel,
   output logic              polarity,
   output logic              wr_lock,
   output logic              mem_lock,
   output logic              reset_cmd,
   output logic              drop_err
);
   import lockcfg_pkg::*;

   localparam int unsigned TRIP_BYTES = TRIP_W / BYTE_W;
   localparam int unsigned TIME_BYTES = TIME_W / BYTE_W;
   localparam int unsigned EVT_BYTES  = EVT_W / BYTE_W;
   localparam int unsigned USER_BASE  = A_CFG + 1;
   localparam int unsigned TRIP_BASE  = USER_BASE + USER_BYTES;
   localparam int unsigned TIME_BASE  = TRIP_BASE + TRIP_BYTES;
   localparam int unsigned EVT_BASE   = TIME_BASE + TIME_BYTES;
   localparam int unsigned MAP_END    = EVT_BASE + EVT_BYTES;

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("lockcfg_regfile: ADDR_W must reach the command locations");
      end
      if ((TRIP_W % BYTE_W) != 0 || (TIME_W % BYTE_W) != 0 || (EVT_W % BYTE_W) != 0) begin : g_bad_width
         $error("lockcfg_regfile: value widths must be whole bytes");
      end
      if (MAP_END > A_RSTCMD) begin : g_bad_map
         $error("lockcfg_regfile: storage overlaps the command locations");
      end
   endgenerate

   logic wr_ok;
   cfg_t cfg_q;
   logic [7:0] cfg_byte;
   logic [USER_BYTES*8-1:0] user_v;
   logic reset_ok;

   assign wr_ok = wr_en && !busy;

   // permanent write locks, each armed by repeated key writes
   lockcfg_keyarm #(.REPEAT(KEY_REPEAT), .ADDR_W(ADDR_W), .KEY_ADDR(A_WLKCMD), .KEY_VAL(K_WLKCMD))
      u_wlock (.clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(addr), .wdata(wdata), .locked(wr_lock));
   lockcfg_keyarm #(.REPEAT(KEY_REPEAT), .ADDR_W(ADDR_W), .KEY_ADDR(A_MLKCMD), .KEY_VAL(K_MLKCMD))
      u_mlock (.clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(addr), .wdata(wdata), .locked(mem_lock));

   lockcfg_bytebank #(.NBYTES(USER_BYTES), .ADDR_W(ADDR_W), .BASE(USER_BASE))
      u_user (.clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(addr), .wdata(wdata),
              .protect(mem_lock), .bytes_q(user_v));
   lockcfg_bytebank #(.NBYTES(TRIP_BYTES), .ADDR_W(ADDR_W), .BASE(TRIP_BASE))
      u_trip (.clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .addr(addr), .wdata(wdata),
              .protect(wr_lock), .bytes_q(trip_point));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_ok && !wr_lock && (32'(addr) == A_CFG)) begin
         cfg_q.pin_role <= wdata[7];
         cfg_q.out_sel  <= wdata[3];
         cfg_q.rst_en   <= wdata[2];
         cfg_q.polarity <= wdata[1];
      end
   end

   assign reset_ok = cfg_q.rst_en || (cfg_q.pin_role && ext_rst_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_cmd <= 1'b0;
         drop_err  <= 1'b0;
      end else begin
         reset_cmd <= wr_ok && reset_ok && (32'(addr) == A_RSTCMD) && (wdata == K_RSTCMD);
         if (wr_en && busy) drop_err <= 1'b1;
      end
   end

   assign cfg_byte = {cfg_q.pin_role, alarm_flag_in, wr_lock, mem_lock,
                      cfg_q.out_sel, cfg_q.rst_en, cfg_q.polarity, rollover_in};
   assign pin_role = cfg_q.pin_role;
   assign out_sel  = cfg_q.out_sel;
   assign polarity = cfg_q.polarity;

   lockcfg_rdmux #(.ADDR_W(ADDR_W), .USER_BYTES(USER_BYTES), .TRIP_BYTES(TRIP_BYTES),
                   .TIME_BYTES(TIME_BYTES), .EVT_BYTES(EVT_BYTES), .USER_BASE(USER_BASE),
                   .TRIP_BASE(TRIP_BASE), .TIME_BASE(TIME_BASE), .EVT_BASE(EVT_BASE))
      u_rd (.addr(addr), .cfg_byte(cfg_byte), .user_v(user_v), .trip_v(trip_point),
            .time_v(time_in), .evt_v(events_in), .rdata(rdata));
endmodule

// File: rtl/lockcfg_checker.sv
module lockcfg_checker #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned TRIP_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              busy,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        wdata,
   input logic [7:0]        rdata,
   input logic              reset_cmd,
   input logic              wr_lock,
   input logic              mem_lock,
   input logic              drop_err,
   input logic [TRIP_W-1:0] trip_point,
   input logic              pin_role,
   input logic              out_sel,
   input logic              polarity
);
   p_pulse_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reset_cmd |=> !reset_cmd);
   p_pulse_needs_key_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(reset_cmd) |-> $past(wr_en && !busy && (32'(addr) == 32'h1D) && (wdata == 8'h55)));
   p_wlock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lock |=> wr_lock);
   p_wlock_needs_key_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_lock) |-> $past(wr_en && !busy && (32'(addr) == 32'h1E) && (wdata == 8'hAA)));
   p_mlock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_lock |=> mem_lock);
   p_trip_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lock |=> $stable(trip_point));
   p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lock |=> $stable({pin_role, out_sel, polarity}));
   p_cmd_reads_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (32'(addr) >= 32'h15) |-> (rdata == 8'h00));
   p_busy_flags_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> drop_err);
   p_busy_no_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> !reset_cmd);
   p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      drop_err |=> drop_err);
endmodule

bind lockcfg_regfile lockcfg_checker #(.ADDR_W(ADDR_W), .TRIP_W(TRIP_W)) u_chk (.*);

// File: tb/sim_lockcfg_regfile.sv
module sim_lockcfg_regfile;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0, busy = 1'b0, ext_rst_en = 1'b0;
   logic alarm_flag_in = 1'b0, rollover_in = 1'b0;
   logic [4:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [31:0] time_in = 32'hDEADBEEF;
   logic [15:0] events_in = 16'h1234;
   logic [7:0] rdata;
   logic [31:0] trip_point;
   logic pin_role, out_sel, polarity, wr_lock, mem_lock, reset_cmd, drop_err;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lockcfg_regfile u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .busy(busy), .rdata(rdata), .ext_rst_en(ext_rst_en), .alarm_flag_in(alarm_flag_in),
      .rollover_in(rollover_in), .time_in(time_in), .events_in(events_in),
      .trip_point(trip_point), .pin_role(pin_role), .out_sel(out_sel), .polarity(polarity),
      .wr_lock(wr_lock), .mem_lock(mem_lock), .reset_cmd(reset_cmd), .drop_err(drop_err));

   // {addr, write data, expected read-back at that address}
   localparam int NV = 13;
   localparam logic [20:0] VEC [NV] = '{
      {5'h01, 8'h3C, 8'h3C}, {5'h0A, 8'hA5, 8'hA5}, {5'h0B, 8'h11, 8'h11},
      {5'h0E, 8'h44, 8'h44}, {5'h00, 8'hFF, 8'h8F}, {5'h00, 8'h00, 8'h01},
      {5'h15, 8'h77, 8'h00}, {5'h1C, 8'h12, 8'h00}, {5'h1D, 8'h13, 8'h00},
      {5'h0F, 8'h99, 8'hEF}, {5'h12, 8'h00, 8'hDE}, {5'h14, 8'h00, 8'h12},
      {5'h13, 8'h55, 8'h34}};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // ends at the falling edge after the capturing edge
   task automatic wr(input logic [4:0] a, input logic [7:0] d, input logic b = 1'b0);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d; busy = b;
      @(negedge clk);
      wr_en = 1'b0; busy = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] v);
      addr = a;
      #1;
      v = rdata;
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] v;
      do_reset();
      // R1 reset state
      rd(5'h00, v); chk("R1 cfg", v, 8'h00);
      rd(5'h05, v); chk("R1 user", v, 8'h00);
      chk("R1 trip", trip_point, 32'h0);
      chk("R1 flags", {wr_lock, mem_lock, drop_err, reset_cmd}, 4'b0);

      // table walk: R2 R3 R10
      rollover_in = 1'b1;
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][20:16], VEC[i][15:8]);
         rd(VEC[i][20:16], v);
         chk($sformatf("R2/R3/R10 vec%0d", i), v, VEC[i][7:0]);
         chk($sformatf("R4 vec%0d no pulse", i), reset_cmd, 1'b0);
      end
      chk("R3 trip out", trip_point, 32'h4400_0011);
      alarm_flag_in = 1'b1; rollover_in = 1'b0;
      rd(5'h00, v); chk("R2 alarm bit", v, 8'h40);
      alarm_flag_in = 1'b0;

      // R4 reset permission
      wr(5'h1D, 8'h55); chk("R4 no permission", reset_cmd, 1'b0);
      wr(5'h00, 8'h80);
      wr(5'h1D, 8'h55); chk("R4 pin role, pin low", reset_cmd, 1'b0);
      ext_rst_en = 1'b1;
      wr(5'h1D, 8'h55); chk("R4 pin role, pin high", reset_cmd, 1'b1);
      @(negedge clk); chk("R4 width", reset_cmd, 1'b0);
      ext_rst_en = 1'b0;
      wr(5'h00, 8'h06);
      wr(5'h1D, 8'h55); chk("R4 enable bit", reset_cmd, 1'b1);
      wr(5'h1D, 8'h54); chk("R4 wrong key", reset_cmd, 1'b0);

      // R11 busy drops writes
      wr(5'h02, 8'hEE, 1'b1);
      rd(5'h02, v); chk("R11 dropped data", v, 8'h00);
      chk("R11 sticky err", drop_err, 1'b1);
      wr(5'h1D, 8'h55, 1'b1); chk("R11 no pulse", reset_cmd, 1'b0);
      wr(5'h1E, 8'hAA);
      wr(5'h1E, 8'hAA, 1'b1); chk("R11 no arm step", wr_lock, 1'b0);
      chk("R11 err held", drop_err, 1'b1);

      // R7 cancellation (one key already armed above)
      wr(5'h01, 8'h5A);
      wr(5'h1E, 8'hAA); chk("R7 other addr cancels", wr_lock, 1'b0);
      wr(5'h1E, 8'hAB);
      wr(5'h1E, 8'hAA); chk("R7 other value cancels", wr_lock, 1'b0);
      // R5 lock
      wr(5'h1E, 8'hAA); chk("R5 locked", wr_lock, 1'b1);
      rd(5'h1E, v); chk("R10 key loc reads 0", v, 8'h00);
      rd(5'h00, v); chk("R5 cfg bit5", v, 8'h26);

      // R8 behaviour under write lock
      wr(5'h00, 8'h00);
      rd(5'h00, v); chk("R8 cfg frozen", v, 8'h26);
      chk("R8 polarity held", polarity, 1'b1);
      wr(5'h0B, 8'h99);
      rd(5'h0B, v); chk("R8 trip frozen", v, 8'h11);
      wr(5'h03, 8'hC3);
      rd(5'h03, v); chk("R8 user writable", v, 8'hC3);
      wr(5'h1D, 8'h55); chk("R8 reset still works", reset_cmd, 1'b1);
      wr(5'h1E, 8'h00); chk("R5 lock permanent", wr_lock, 1'b1);

      // phase B: memory lock
      do_reset();
      chk("R1 locks cleared", {wr_lock, mem_lock, drop_err}, 3'b0);
      wr(5'h04, 8'h21);
      wr(5'h1F, 8'hF0); chk("R7 single key", mem_lock, 1'b0);
      wr(5'h1F, 8'hF0); chk("R6 locked", mem_lock, 1'b1);
      rd(5'h1F, v); chk("R10 mem key reads 0", v, 8'h00);
      wr(5'h04, 8'h77);
      rd(5'h04, v); chk("R9 user frozen", v, 8'h21);
      wr(5'h00, 8'h0A);
      rd(5'h00, v); chk("R9 cfg writable", v, 8'h1A);
      wr(5'h0C, 8'h5E);
      chk("R9 trip writable", trip_point, 32'h0000_5E00);
      chk("R6 wr_lock unaffected", wr_lock, 1'b0);
      wr(5'h1F, 8'h00); chk("R6 lock permanent", mem_lock, 1'b1);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule